// File: doc/BRIEF.md
# Data-Capture Issue Queue

This block is a small out-of-order issue queue that keeps operand values inside its own entries. Each cycle it may accept one instruction: an opcode, a destination tag and two source operands. For each operand it gets a tag, a ready flag and a value. The instruction goes into a free entry. An operand that was not ready at dispatch waits there until a result with a matching tag appears on the broadcast bus. The same tag comparison that marks the operand ready also latches the broadcast value into the entry.

An entry bids for issue once both of its operands are ready. A fixed-position arbiter grants the lowest-numbered bidding entry. The granted entry presents its opcode, destination tag and both operand values straight to execution, so no register file is read after dispatch. The entry is released at the clock edge that ends the issue cycle.

Top module: `rs_data_capture`

## Requirements
- R1: After reset, no entry is occupied: `full_o` is 0 and `iss_valid_o` is 0.
- R2: An instruction dispatched with both operands ready can issue in the cycle after dispatch, with the dispatched opcode, destination tag and values.
- R3: A not-ready operand whose source tag equals the tag of a valid broadcast takes the broadcast value and becomes ready. A broadcast with a different tag changes nothing. An operand that is already ready keeps its value even when a later broadcast carries its tag.
- R4: If a dispatch and a valid broadcast happen in the same cycle, a not-ready dispatched operand whose tag equals the broadcast tag is stored as ready, holding the broadcast value.
- R5: An entry bids only when both of its operands are ready. When several entries bid, the lowest-numbered one is granted.
- R6: `iss_valid_o` is high in exactly the cycles in which at least one entry bids. It is a combinational output from the entry state, with no extra register.
- R7: An entry is freed at the clock edge that ends its issue cycle. It can receive a new dispatch from the next cycle on.
- R8: A dispatch goes to the lowest-numbered free entry. `full_o` is high when every entry is occupied, and a dispatch offered while `full_o` is high is dropped.
- R9: A broadcast with `bc_valid_i` low has no effect on any entry, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | OP_W | Opcode of the dispatched instruction |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_src_l_i | input | TAG_W | Left source tag |
| disp_rdy_l_i | input | 1 | Left operand value already available |
| disp_val_l_i | input | DATA_W | Left operand value |
| disp_src_r_i | input | TAG_W | Right source tag |
| disp_rdy_r_i | input | 1 | Right operand value already available |
| disp_val_r_i | input | DATA_W | Right operand value |
| full_o | output | 1 | No free entry; dispatch is dropped |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Broadcast destination tag |
| bc_data_i | input | DATA_W | Broadcast result value |
| iss_valid_o | output | 1 | An instruction issues this cycle |
| iss_op_o | output | OP_W | Issued opcode |
| iss_dst_o | output | TAG_W | Issued destination tag |
| iss_val_l_o | output | DATA_W | Issued left operand value |
| iss_val_r_o | output | DATA_W | Issued right operand value |

## Verification
The assertions require no discipline from the dispatch side. A dispatch while `full_o` is high is simply dropped, and the checks only require that a write never lands on an occupied entry. They do take for granted that the broadcast tag and value are meaningful only when `bc_valid_i` is high, so the operand checks are all qualified by that valid bit. The random stimulus keeps every tag in a narrow range, so wakeups, same-cycle captures and tags nobody waits on all happen often. It also dispatches often enough to keep the queue full and to offer dispatches that are refused.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_ENTRIES = 8;
  localparam int unsigned RS_TAG_W   = 6;
  localparam int unsigned RS_DATA_W  = 32;
  localparam int unsigned RS_OP_W    = 5;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | req_i[i];
    assign gnt_o[i]   = req_i[i] & ~seen[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic              load_rdy_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              live_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0]  tag_q;
  logic              rdy_q;
  logic [DATA_W-1:0] val_q;
  logic              hit_load, hit_wake;

  // bypass for a broadcast that lands in the dispatch cycle
  assign hit_load = bc_valid_i & ~load_rdy_i & (bc_tag_i == load_tag_i);
  assign hit_wake = live_i & ~rdy_q & bc_valid_i & (bc_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      rdy_q <= 1'b0;
      val_q <= '0;
    end else if (load_i) begin
      tag_q <= load_tag_i;
      rdy_q <= load_rdy_i | hit_load;
      val_q <= hit_load ? bc_data_i : load_val_i;
    end else if (hit_wake) begin
      rdy_q <= 1'b1;
      val_q <= bc_data_i;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  // R3
  ready_value_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !load_i) |=> (rdy_q && $stable(val_q)));

  // R4
  dispatch_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !load_rdy_i && bc_valid_i && bc_tag_i == load_tag_i)
      |=> (rdy_q && val_q == $past(bc_data_i)));

  // R9
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !bc_valid_i) |=> ($stable(rdy_q) && $stable(val_q)));
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OP_W-1:0]   wr_op_i,
  input  logic [TAG_W-1:0]  wr_dst_i,
  input  logic [TAG_W-1:0]  wr_src_l_i,
  input  logic              wr_rdy_l_i,
  input  logic [DATA_W-1:0] wr_val_l_i,
  input  logic [TAG_W-1:0]  wr_src_r_i,
  input  logic              wr_rdy_r_i,
  input  logic [DATA_W-1:0] wr_val_r_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              gnt_i,
  output logic              busy_o,
  output logic              bid_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  dst_o,
  output logic [DATA_W-1:0] val_l_o,
  output logic [DATA_W-1:0] val_r_o
);
  logic            busy_q;
  logic [OP_W-1:0] op_q;
  logic [TAG_W-1:0] dst_q;
  logic            rdy_l, rdy_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      dst_q  <= '0;
    end else if (wr_i) begin
      busy_q <= 1'b1;
      op_q   <= wr_op_i;
      dst_q  <= wr_dst_i;
    end else if (gnt_i) begin
      busy_q <= 1'b0;
    end
  end

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd_l (
    .clk_i, .rst_ni,
    .load_i(wr_i), .load_tag_i(wr_src_l_i), .load_rdy_i(wr_rdy_l_i), .load_val_i(wr_val_l_i),
    .live_i(busy_q), .bc_valid_i, .bc_tag_i, .bc_data_i,
    .rdy_o(rdy_l), .val_o(val_l_o)
  );

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd_r (
    .clk_i, .rst_ni,
    .load_i(wr_i), .load_tag_i(wr_src_r_i), .load_rdy_i(wr_rdy_r_i), .load_val_i(wr_val_r_i),
    .live_i(busy_q), .bc_valid_i, .bc_tag_i, .bc_data_i,
    .rdy_o(rdy_r), .val_o(val_r_o)
  );

  assign busy_o = busy_q;
  assign bid_o  = busy_q & rdy_l & rdy_r;
  assign op_o   = op_q;
  assign dst_o  = dst_q;

  // R5
  grant_needs_bid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> (busy_q && rdy_l && rdy_r));

  // R7
  free_after_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> !busy_q);

  // R8
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !busy_q);
endmodule

// File: rtl/rs_data_capture.sv
module rs_data_capture
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENT = RS_ENTRIES,
  parameter int unsigned TAG_W   = RS_TAG_W,
  parameter int unsigned DATA_W  = RS_DATA_W,
  parameter int unsigned OP_W    = RS_OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_dst_i,
  input  logic [TAG_W-1:0]  disp_src_l_i,
  input  logic              disp_rdy_l_i,
  input  logic [DATA_W-1:0] disp_val_l_i,
  input  logic [TAG_W-1:0]  disp_src_r_i,
  input  logic              disp_rdy_r_i,
  input  logic [DATA_W-1:0] disp_val_r_i,
  output logic              full_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              iss_valid_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [TAG_W-1:0]  iss_dst_o,
  output logic [DATA_W-1:0] iss_val_l_o,
  output logic [DATA_W-1:0] iss_val_r_o
);
  logic [NUM_ENT-1:0] busy, bid, gnt, alloc_oh, wr;
  logic               any_free;
  logic [OP_W-1:0]    ent_op  [NUM_ENT];
  logic [TAG_W-1:0]   ent_dst [NUM_ENT];
  logic [DATA_W-1:0]  ent_vl  [NUM_ENT];
  logic [DATA_W-1:0]  ent_vr  [NUM_ENT];

  rs_prio_pick #(.N(NUM_ENT)) u_free_pick (
    .req_i(~busy), .gnt_o(alloc_oh), .any_o(any_free)
  );

  rs_prio_pick #(.N(NUM_ENT)) u_iss_pick (
    .req_i(bid), .gnt_o(gnt), .any_o(iss_valid_o)
  );

  assign full_o = ~any_free;
  assign wr     = {NUM_ENT{disp_valid_i}} & alloc_oh;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_ent (
      .clk_i, .rst_ni,
      .wr_i(wr[i]), .wr_op_i(disp_op_i), .wr_dst_i(disp_dst_i),
      .wr_src_l_i(disp_src_l_i), .wr_rdy_l_i(disp_rdy_l_i), .wr_val_l_i(disp_val_l_i),
      .wr_src_r_i(disp_src_r_i), .wr_rdy_r_i(disp_rdy_r_i), .wr_val_r_i(disp_val_r_i),
      .bc_valid_i, .bc_tag_i, .bc_data_i,
      .gnt_i(gnt[i]),
      .busy_o(busy[i]), .bid_o(bid[i]),
      .op_o(ent_op[i]), .dst_o(ent_dst[i]), .val_l_o(ent_vl[i]), .val_r_o(ent_vr[i])
    );
  end

  // one-hot AND-OR payload mux
  always_comb begin
    iss_op_o    = '0;
    iss_dst_o   = '0;
    iss_val_l_o = '0;
    iss_val_r_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      iss_op_o    |= {OP_W{gnt[i]}}   & ent_op[i];
      iss_dst_o   |= {TAG_W{gnt[i]}}  & ent_dst[i];
      iss_val_l_o |= {DATA_W{gnt[i]}} & ent_vl[i];
      iss_val_r_o |= {DATA_W{gnt[i]}} & ent_vr[i];
    end
  end

  // R5
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  // R8
  full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !iss_valid_o) |=> full_o);

  // R6
  issue_when_bid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bid != '0) |-> (iss_valid_o && $countones(gnt) == 1));
endmodule

// File: tb/rs_data_capture_tb.sv
`timescale 1ns/1ps
module rs_data_capture_tb;
  import rs_pkg::*;
  localparam int N  = RS_ENTRIES;
  localparam int TW = RS_TAG_W;
  localparam int DW = RS_DATA_W;
  localparam int OW = RS_OP_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          disp_valid, disp_rdy_l, disp_rdy_r, bc_valid, full;
  logic [OW-1:0] disp_op, iss_op;
  logic [TW-1:0] disp_dst, disp_src_l, disp_src_r, bc_tag, iss_dst;
  logic [DW-1:0] disp_val_l, disp_val_r, bc_data, iss_vl, iss_vr;
  logic          iss_valid;

  rs_data_capture u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_op_i(disp_op), .disp_dst_i(disp_dst),
    .disp_src_l_i(disp_src_l), .disp_rdy_l_i(disp_rdy_l), .disp_val_l_i(disp_val_l),
    .disp_src_r_i(disp_src_r), .disp_rdy_r_i(disp_rdy_r), .disp_val_r_i(disp_val_r),
    .full_o(full),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
    .iss_valid_o(iss_valid), .iss_op_o(iss_op), .iss_dst_o(iss_dst),
    .iss_val_l_o(iss_vl), .iss_val_r_o(iss_vr)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model of entry state
  bit            m_busy [N];
  bit            m_rl [N], m_rr [N];
  logic [TW-1:0] m_sl [N], m_sr [N], m_dst [N];
  logic [OW-1:0] m_op [N];
  logic [DW-1:0] m_vl [N], m_vr [N];

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int first_bid();
    for (int i = 0; i < N; i++) if (m_busy[i] && m_rl[i] && m_rr[i]) return i;
    return -1;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input bit dv, input logic [OW-1:0] op, input logic [TW-1:0] dst,
                      input logic [TW-1:0] sl, input bit rl, input logic [DW-1:0] vl,
                      input logic [TW-1:0] sr, input bit rr, input logic [DW-1:0] vr,
                      input bit bv, input logic [TW-1:0] bt, input logic [DW-1:0] bd);
    int g, f;
    @(negedge clk);
    disp_valid = dv; disp_op = op; disp_dst = dst;
    disp_src_l = sl; disp_rdy_l = rl; disp_val_l = vl;
    disp_src_r = sr; disp_rdy_r = rr; disp_val_r = vr;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    #1;
    g = first_bid();
    f = first_free();
    check("R8", "full", 64'(full), 64'(f < 0));
    check("R6", "iss_valid", 64'(iss_valid), 64'(g >= 0));
    if (g >= 0) begin
      check(req, "iss_op",  64'(iss_op),  64'(m_op[g]));
      check(req, "iss_dst", 64'(iss_dst), 64'(m_dst[g]));
      check(req, "iss_vl",  64'(iss_vl),  64'(m_vl[g]));
      check(req, "iss_vr",  64'(iss_vr),  64'(m_vr[g]));
    end
    // state update for the coming edge
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && bv) begin
        if (!m_rl[i] && m_sl[i] == bt) begin m_rl[i] = 1; m_vl[i] = bd; end
        if (!m_rr[i] && m_sr[i] == bt) begin m_rr[i] = 1; m_vr[i] = bd; end
      end
    end
    if (g >= 0) m_busy[g] = 0;
    if (dv && f >= 0) begin
      m_busy[f] = 1; m_op[f] = op; m_dst[f] = dst; m_sl[f] = sl; m_sr[f] = sr;
      m_rl[f] = rl | (bv && !rl && bt == sl);
      m_vl[f] = (bv && !rl && bt == sl) ? bd : vl;
      m_rr[f] = rr | (bv && !rr && bt == sr);
      m_vr[f] = (bv && !rr && bt == sr) ? bd : vr;
    end
  endtask

  task automatic idle(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 0, '0, '0, '0, 0, '0, '0, 0, '0, 0, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_rl[i] = 0; m_rr[i] = 0;
    end
    disp_valid = 0; disp_op = '0; disp_dst = '0; disp_src_l = '0; disp_rdy_l = 0;
    disp_val_l = '0; disp_src_r = '0; disp_rdy_r = 0; disp_val_r = '0;
    bc_valid = 0; bc_tag = '0; bc_data = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1", "full after reset", 64'(full), 64'd0);
    check("R1", "iss_valid after reset", 64'(iss_valid), 64'd0);

    // R2: ready-at-dispatch issues next cycle
    step("R2", 1, 5'd3, 6'd9, 6'd1, 1, 32'h1111, 6'd2, 1, 32'h2222, 0, '0, '0);
    idle("R2", 2);
    // R3: wait on left tag 5; mismatching tag, then R9 idle bus with matching tag
    step("R3", 1, 5'd4, 6'd10, 6'd5, 0, 32'hdead, 6'd2, 1, 32'h3333, 0, '0, '0);
    step("R3", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd6, 32'hbad0);
    step("R9", 0, '0, '0, '0, 0, '0, '0, 0, '0, 0, 6'd5, 32'hbad1);
    step("R3", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd5, 32'h5555);
    idle("R3", 2);
    // R3: ready operand with tag 4 must not be overwritten by broadcast of tag 4
    step("R3", 1, 5'd7, 6'd11, 6'd4, 1, 32'h4444, 6'd6, 0, '0, 0, '0, '0);
    step("R3", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd4, 32'hbad2);
    step("R3", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd6, 32'h6666);
    idle("R3", 2);
    // R4: dispatch and matching broadcast in the same cycle
    step("R4", 1, 5'd8, 6'd12, 6'd2, 0, 32'hbad3, 6'd3, 0, 32'hbad4, 1, 6'd2, 32'h7777);
    step("R4", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd3, 32'h8888);
    idle("R4", 2);
    // R8: fill all entries with waiting instructions, then offer while full
    for (int i = 0; i < N; i++)
      step("R8", 1, OW'(i), TW'(20 + i), 6'd7, 0, '0, TW'(i % 3), 1, DW'(i), 0, '0, '0);
    step("R8", 1, 5'd31, 6'd63, 6'd0, 1, 32'hbad5, 6'd0, 1, 32'hbad6, 0, '0, '0);
    // R5: wake all at once; lowest index issues first
    step("R5", 0, '0, '0, '0, 0, '0, '0, 0, '0, 1, 6'd7, 32'h9999);
    // R7: reuse freed entries as they drain
    for (int i = 0; i < N; i++)
      step("R7", 1, OW'(i + 8), TW'(40 + i), 6'd1, 1, DW'(i * 3), 6'd2, 1, DW'(i * 5), 0, '0, '0);
    idle("R7", 2 * N);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      step("R5",
           ($urandom_range(0, 9) < 6), OW'($urandom), TW'($urandom_range(0, 7)),
           TW'($urandom_range(0, 7)), ($urandom_range(0, 9) < 3), DW'($urandom),
           TW'($urandom_range(0, 7)), ($urandom_range(0, 9) < 3), DW'($urandom),
           ($urandom_range(0, 9) < 5), TW'($urandom_range(0, 7)), DW'($urandom));
    end
    idle("R5", 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule